// File: doc/BRIEF.md
# Two-Output Maskable Interrupt Router

This block collects up to `N_SRC` event lines into one latched status register and drives two interrupt outputs from it. Every event line is watched for a low-to-high transition. A transition sets that source's status bit, and the bit stays set until software clears it by writing a one to it. Each output has its own enable register. The "hi" output is meant for urgent events and the "lo" output for background events, so software can route any source to one output, to both, or to neither. A source enabled on neither output still records its events in the status register, and software reads them by polling.

Software reaches the status register and both enable registers through a simple register port. The port uses single-cycle write strobes and read strobes. Read data comes back one cycle after the strobe, flagged by a valid pulse. Both interrupt outputs are registered, so they never glitch on combinational paths.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset, the status register and both enable registers are zero, both interrupt outputs are low, and the read-valid output is low.
- R2: A 0-to-1 transition on `event_i[k]` sets status bit k at the next clock edge. An event line that stays high does not set its bit again after the bit has been cleared; only a new transition does.
- R3: A write to address 0 (status) clears each status bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged.
- R4: If a transition on `event_i[k]` and a write that clears bit k happen in the same cycle, status bit k ends up set.
- R5: `irq_hi_o` is high exactly one cycle after some status bit is set while the same bit of the hi enable register (address 1) is 1.
- R6: `irq_lo_o` behaves the same way using the lo enable register (address 2), independently of the hi enable register.
- R7: A source whose bit is 0 in both enable registers never raises either output, but its status bit is still set and can be read.
- R8: The enable registers read back as written. Address 3 reads as zero, and writes to it change no register. A write to one address leaves the other registers unchanged.
- R9: A read strobe returns the addressed register's value on `reg_rdata_o`, with `reg_rvalid_o` high, in the cycle after the strobe. `reg_rvalid_o` is high only in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | N_SRC | Event lines; a rising transition sets the matching status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 hi enable, 2 lo enable, 3 unused |
| reg_wdata_i | input | N_SRC | Write data (write-one-to-clear for status) |
| reg_rdata_o | output | N_SRC | Read data, valid while reg_rvalid_o is high |
| reg_rvalid_o | output | 1 | High for one cycle after each read strobe |
| irq_hi_o | output | 1 | Interrupt output driven through the hi enable register |
| irq_lo_o | output | 1 | Interrupt output driven through the lo enable register |

## Verification
The two functions that can land in the same cycle are the hardware setting of a status bit and the software clear of that bit. The bench raises an event line on the same falling edge where it presents a status write. The write data carries a one for that line and a one for another bit that is already set. A later read must show the new event still set and the other bit cleared. The bench also checks that the lo output falls once its only enabled source is gone.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ADDR_W = 2;
  localparam int PIN_CNT = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASK_HI = 2'd1,
    SEL_MASK_LO = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_edge_status.sv
module irq_edge_status #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] event_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] rise_o
);

  logic [N_SRC-1:0] ev_prev;
  logic [N_SRC-1:0] status_q;

  assign rise_o = event_i & ~ev_prev;

  // The set term wins over the clear term, bit by bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_prev  <= '0;
      status_q <= '0;
    end else begin
      ev_prev  <= event_i;
      status_q <= (status_q & ~clr_i) | rise_o;
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [N_SRC-1:0]              wdata_i,
  output logic [PIN_CNT-1:0][N_SRC-1:0] mask_o
);

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_mask
    localparam logic [ADDR_W-1:0] MY_SEL = ADDR_W'(int'(SEL_MASK_HI) + p);
    logic [N_SRC-1:0] mask_q;

    always_ff @(posedge clk) begin
      if (rst)
        mask_q <= '0;
      else if (wr_i && addr_i == MY_SEL)
        mask_q <= wdata_i;
    end

    assign mask_o[p] = mask_q;
  end

endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] status_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             pin_o
);

  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst)
      pin_q <= 1'b0;
    else
      pin_q <= |(status_i & mask_i);
  end

  assign pin_o = pin_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  event_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              irq_hi_o,
  output logic              irq_lo_o
);

  logic [N_SRC-1:0]              status_w;
  logic [N_SRC-1:0]              rise_w;
  logic [N_SRC-1:0]              clr_w;
  logic [PIN_CNT-1:0][N_SRC-1:0] masks_w;
  logic [PIN_CNT-1:0]            pins_w;
  logic [N_SRC-1:0]              rdata_q;
  logic                          rvalid_q;

  assign clr_w = (reg_wr_i && reg_addr_i == SEL_STATUS) ? reg_wdata_i : '0;

  irq_edge_status #(.N_SRC(N_SRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .event_i  (event_i),
    .clr_i    (clr_w),
    .status_o (status_w),
    .rise_o   (rise_w)
  );

  irq_mask_bank #(.N_SRC(N_SRC)) u_masks (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .mask_o  (masks_w)
  );

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    irq_pin_merge #(.N_SRC(N_SRC)) u_merge (
      .clk      (clk),
      .rst      (rst),
      .status_i (status_w),
      .mask_i   (masks_w[p]),
      .pin_o    (pins_w[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd_i;
      if (reg_rd_i) begin
        case (reg_addr_i)
          SEL_STATUS:  rdata_q <= status_w;
          SEL_MASK_HI: rdata_q <= masks_w[0];
          SEL_MASK_LO: rdata_q <= masks_w[1];
          default:     rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata_o  = rdata_q;
  assign reg_rvalid_o = rvalid_q;
  assign irq_hi_o     = pins_w[0];
  assign irq_lo_o     = pins_w[1];

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_SRC = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] rise,
  input logic [N_SRC-1:0] clr,
  input logic [N_SRC-1:0] mask_hi,
  input logic [N_SRC-1:0] mask_lo,
  input logic             irq_hi,
  input logic             irq_lo,
  input logic             rvalid,
  input logic             rd
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_hi && !irq_lo && !rvalid && status == '0));

  // R2
  set_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & ~$past(status)) & ~$past(rise)) == '0);

  // R3
  clear_needs_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(status) & ~status) & ~$past(clr)) == '0);

  // R4
  rise_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rise) & ~status) == '0);

  // R5
  hi_pin_chk: assert property (@(posedge clk) disable iff (rst)
    irq_hi == (($past(status) & $past(mask_hi)) != '0));

  // R6
  lo_pin_chk: assert property (@(posedge clk) disable iff (rst)
    irq_lo == (($past(status) & $past(mask_lo)) != '0));

  // R7
  poll_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((mask_hi | mask_lo) == '0) |=> (!irq_hi && !irq_lo));

  // R9
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid == $past(rd));

endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .status  (status_w),
  .rise    (rise_w),
  .clr     (clr_w),
  .mask_hi (masks_w[0]),
  .mask_lo (masks_w[1]),
  .irq_hi  (irq_hi_o),
  .irq_lo  (irq_lo_o),
  .rvalid  (reg_rvalid_o),
  .rd      (reg_rd_i)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ev = '0;
  logic         wr = 1'b0;
  logic         rd = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         rvalid, irq_hi, irq_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  irq_router #(.N_SRC(N)) uut (
    .clk          (clk),
    .rst          (rst),
    .event_i      (ev),
    .reg_wr_i     (wr),
    .reg_rd_i     (rd),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .reg_rvalid_o (rvalid),
    .irq_hi_o     (irq_hi),
    .irq_lo_o     (irq_lo)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pins(input bit hi, input bit lo, input string tag);
    check(irq_hi == hi && irq_lo == lo, tag,
          {30'd0, irq_hi, irq_lo}, {30'd0, hi, lo});
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    q.push_back('{exp: exp, tag: tag});
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops the expected read data as each valid result appears.
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 read data with no request", rdata, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rdata === e.exp, e.tag, rdata, e.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    pins(1'b0, 1'b0, "R1 outputs low after reset");
    check(rvalid == 1'b0, "R1 rvalid low after reset", {31'd0, rvalid}, '0);
    rd_reg(2'd0, 32'h0, "R1 status zero");
    rd_reg(2'd1, 32'h0, "R1 hi enable zero");
    rd_reg(2'd2, 32'h0, "R1 lo enable zero");

    // Poll-only source.
    @(negedge clk); ev[3] = 1'b1;
    idle(2);
    pins(1'b0, 1'b0, "R7 unmasked source raises no output");
    rd_reg(2'd0, 32'h8, "R2 R7 rising edge sets status bit 3");

    // Clear while the line stays high: no new set.
    wr_reg(2'd0, 32'h8);
    idle(2);
    rd_reg(2'd0, 32'h0, "R2 R3 held level does not set again");

    // Several sources, partial clear.
    @(negedge clk); ev[7:4] = 4'hF;
    idle(1);
    wr_reg(2'd0, 32'h30);
    rd_reg(2'd0, 32'hC0, "R3 clear only bits written as one");

    // Route bit 7 to the hi output.
    wr_reg(2'd1, 32'h80);
    pins(1'b0, 1'b0, "R5 hi output one cycle after enable");
    idle(1);
    pins(1'b1, 1'b0, "R5 hi output raised");

    // Route bit 6 to the lo output.
    wr_reg(2'd2, 32'h40);
    idle(1);
    pins(1'b1, 1'b1, "R6 lo output raised");
    rd_reg(2'd2, 32'h40, "R8 lo enable readback");
    rd_reg(2'd1, 32'h80, "R8 hi enable readback");

    // Clear bit 7: hi falls, lo stays.
    wr_reg(2'd0, 32'h80);
    idle(1);
    pins(1'b0, 1'b1, "R5 R6 hi falls lo holds");
    rd_reg(2'd0, 32'h40, "R3 status after clear of bit 7");

    // Collision: new event on bit 9 with a clear of bits 9 and 6.
    @(negedge clk);
    ev[9] = 1'b1;
    wr = 1'b1; addr = 2'd0; wdata = 32'h240;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    idle(1);
    pins(1'b0, 1'b0, "R6 lo falls after bit 6 cleared");
    rd_reg(2'd0, 32'h200, "R4 event wins over clear");

    // Unused address.
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_reg(2'd3, 32'h0, "R8 unused address reads zero");
    rd_reg(2'd1, 32'h80, "R8 hi enable unchanged");
    rd_reg(2'd2, 32'h40, "R8 lo enable unchanged");
    rd_reg(2'd0, 32'h200, "R8 status unchanged");

    // Top bit routed to both outputs.
    wr_reg(2'd1, 32'h8000_0000);
    wr_reg(2'd2, 32'h8000_0000);
    @(negedge clk); ev[31] = 1'b1;
    idle(1);
    pins(1'b0, 1'b0, "R5 R6 output lags status by one cycle");
    idle(1);
    pins(1'b1, 1'b1, "R5 R6 bit 31 drives both outputs");

    // Release and re-raise bit 9.
    wr_reg(2'd0, 32'h200);
    @(negedge clk); ev[9] = 1'b0;
    @(negedge clk); ev[9] = 1'b1;
    idle(1);
    rd_reg(2'd0, 32'h8000_0200, "R2 new rising edge sets again");

    idle(3);
    check(q.size() == 0, "R9 every read answered", N'(q.size()), '0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule